// File: doc/BRIEF.md
# Register File with Output Holding Latch

A small storage block: a bank of words shares one address between the write and the read side. A word is written at a rising clock edge when the active-low write strobe is low. The read side does not drive the pins straight from the array. It passes through a holding register, which works like an output latch. While the active-low store control is high, that register follows the addressed word. While the control is low, it freezes and keeps its contents. The pins can therefore go on showing an old word after the same location has been written again.

The output stage is separate and tri-state. When the disable input is high, the pins float. The value and its enable are also brought out as plain signals, for use inside the chip. The holding register is a flop with an enable, clocked by the system clock, so no real latch is inferred. A two-state machine (FOLLOW, FREEZE) controls it. At each edge where the store control is high, the machine enters or stays in FOLLOW (FREEZE to FOLLOW, or FOLLOW to FOLLOW). At each edge where the store control is low, it enters or stays in FREEZE (FOLLOW to FREEZE, or FREEZE to FREEZE). The array has no reset. Only the holding register and the state machine are reset.

Top module: `latched_regfile`

## Requirements
- R1: The array holds 16 words of 4 bits, selected by the 4-bit address `addr`. A distinct value written to each address reads back from that address alone.
- R2: A word is written only at a rising edge of `clk` with `wr_n` = 0. With `wr_n` = 1, an edge leaves every word unchanged.
- R3: When `store_n` = 1 at an edge and no write occurs, `q_val` after that edge equals the word at the `addr` sampled at that edge (state FOLLOW).
- R4: When `store_n` = 0 at an edge, `q_val` keeps its value (state FREEZE). Neither a later write to the shown address nor an address change alters it.
- R5: With `out_dis` = 1, `q_oe` = 0 and `q_pad` floats. With `out_dis` = 0, `q_oe` = 1 and `q_pad` equals `q_val`.
- R6: `out_dis` changes neither the stored words nor the holding register, which keeps following while the pins are disabled.
- R7: A write to the addressed word at an edge with `store_n` = 1 shows the written data on `q_val` after that edge.
- R8: While `rst_n` = 0, the holding register is cleared to 0 and the state returns to FOLLOW. The array contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; writes and the holding register update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the holding register and state |
| addr | input | 4 | Word select, shared by write and read |
| din | input | 4 | Write data |
| wr_n | input | 1 | Active-low write strobe |
| store_n | input | 1 | Active-low store control: 1 follows, 0 freezes the output |
| out_dis | input | 1 | High floats the output pins |
| q_val | output | 4 | Holding register value |
| q_oe | output | 1 | Output enable, high when the pins drive |
| q_pad | output | 4 | Tri-state data pins |

## Verification
Every address is loaded with a value that is distinct from the values at the other addresses, and then read back. This separates a correct decode from aliased or stuck address bits. A table of steps then alternates FOLLOW and FREEZE at one address. It writes while following, writes while frozen, moves the address while frozen, and attempts a write with the strobe high. Together these separate write-through, a true hold and write gating. Directed steps disable the pins while the register keeps following, and apply a reset in mid-run to show that only the holding register clears.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
    typedef enum logic {
        HS_FOLLOW = 1'b0,
        HS_FREEZE = 1'b1
    } hold_state_e;
endpackage

// File: rtl/lrf_array.sv
module lrf_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_n,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] nxt_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!wr_n) begin
            mem[addr] <= din;
        end
    end

    always_comb begin
        rd_word  = mem[addr];
        nxt_word = wr_n ? mem[addr] : din;
    end

    // R2: with the strobe high, the addressed word survives the edge
    assert_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> mem[$past(addr)] == $past(rd_word));
endmodule

// File: rtl/lrf_hold.sv
module lrf_hold
    import lrf_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_n,
    input  logic [DATA_W-1:0] nxt_word,
    output logic [DATA_W-1:0] hold_q
);
    hold_state_e state_q;
    hold_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_FOLLOW: if (!store_n) state_d = HS_FREEZE;
            HS_FREEZE: if (store_n)  state_d = HS_FOLLOW;
            default:                 state_d = HS_FOLLOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_FOLLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (state_d == HS_FOLLOW) begin
            hold_q <= nxt_word;
        end
    end

    // R4: a store-low edge keeps the register
    assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !store_n |=> $stable(hold_q));
    // R4: state tracks the sampled store control
    assert_state_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !store_n |=> state_q == HS_FREEZE);
endmodule

// File: rtl/lrf_drive.sv
module lrf_drive #(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] val,
    input  logic              dis,
    output logic              oe,
    output wire  [DATA_W-1:0] pad
);
    assign oe  = ~dis;
    assign pad = oe ? val : {DATA_W{1'bz}};
endmodule

// File: rtl/latched_regfile.sv
module latched_regfile #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_n,
    input  logic              store_n,
    input  logic              out_dis,
    output logic [DATA_W-1:0] q_val,
    output logic              q_oe,
    output wire  [DATA_W-1:0] q_pad
);
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] arr_nxt;

    lrf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .din      (din),
        .wr_n     (wr_n),
        .rd_word  (arr_rd),
        .nxt_word (arr_nxt)
    );

    lrf_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .store_n  (store_n),
        .nxt_word (arr_nxt),
        .hold_q   (q_val)
    );

    lrf_drive #(.DATA_W(DATA_W)) u_drive (
        .val (q_val),
        .dis (out_dis),
        .oe  (q_oe),
        .pad (q_pad)
    );

    // R3: following with no write shows the sampled word
    assert_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (store_n && wr_n) |=> q_val == $past(arr_rd));
    // R7: a write while following appears on the outputs
    assert_write_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_n && !wr_n) |=> q_val == $past(din));
endmodule

// File: tb/sim_latched_regfile.sv
module sim_latched_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [3:0] din = '0;
    logic       wr_n = 1'b1;
    logic       store_n = 1'b1;
    logic       out_dis = 1'b0;
    logic [3:0] q_val;
    logic       q_oe;
    wire  [3:0] q_pad;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    latched_regfile u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .wr_n(wr_n),
        .store_n(store_n), .out_dis(out_dis), .q_val(q_val), .q_oe(q_oe),
        .q_pad(q_pad)
    );

    function automatic logic [3:0] pat(input int a);
        return 4'((a * 7 + 3) & 15);
    endfunction

    // {wr_n, store_n, addr, din, expected q_val}, after all words hold pat()
    localparam logic [13:0] STEPS [9] = '{
        {1'b1, 1'b1, 4'd5,  4'd0, 4'd6},   // R3 follow
        {1'b0, 1'b1, 4'd5,  4'd9, 4'd9},   // R7 write-through
        {1'b1, 1'b0, 4'd5,  4'd0, 4'd9},   // R4 freeze
        {1'b0, 1'b0, 4'd5,  4'd3, 4'd9},   // R4 write while frozen
        {1'b1, 1'b0, 4'd0,  4'd0, 4'd9},   // R4 address move while frozen
        {1'b1, 1'b1, 4'd5,  4'd3, 4'd3},   // R3 shows frozen-time write
        {1'b1, 1'b1, 4'd15, 4'd0, 4'd12},  // R1 top address
        {1'b1, 1'b1, 4'd15, 4'd1, 4'd12},  // R2 strobe high ignored
        {1'b1, 1'b1, 4'd0,  4'd0, 4'd3}    // R1 bottom address
    };
    localparam int STEP_REQ [9] = '{3, 7, 4, 4, 4, 3, 1, 2, 1};

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc();
        cyc();
        // R8: reset state
        check("R8", q_val, 4'd0);
        check("R5", {3'b0, q_oe}, 4'd1);
        rst_n = 1'b1;
        // R1: load every address, frozen so outputs stay put
        store_n = 1'b0;
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a); din = pat(a); wr_n = 1'b0;
            cyc();
        end
        wr_n = 1'b1;
        check("R4", q_val, 4'd0);
        store_n = 1'b1;
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a);
            cyc();
            check("R1", q_val, pat(a));
        end
        for (int i = 0; i < 9; i++) begin
            wr_n = STEPS[i][13]; store_n = STEPS[i][12];
            addr = STEPS[i][11:8]; din = STEPS[i][7:4];
            cyc();
            check($sformatf("R%0d", STEP_REQ[i]), q_val, STEPS[i][3:0]);
        end
        wr_n = 1'b1; store_n = 1'b1;
        // R5, R6: disabled pins, register keeps following
        out_dis = 1'b1; addr = 4'd3;
        cyc();
        check("R5", {3'b0, q_oe}, 4'd0);
        check("R6", q_val, 4'd8);
        addr = 4'd2; din = 4'd10; wr_n = 1'b0;
        cyc();
        wr_n = 1'b1;
        check("R6", q_val, 4'd10);
        out_dis = 1'b0; addr = 4'd9;
        cyc();
        check("R5", {3'b0, q_oe}, 4'd1);
        check("R5", q_pad, 4'd2);
        // R8: mid-run reset clears the register but not the array
        rst_n = 1'b0;
        cyc();
        check("R8", q_val, 4'd0);
        rst_n = 1'b1;
        addr = 4'd2;
        cyc();
        check("R8", q_val, 4'd10);
        addr = 4'd9;
        cyc();
        check("R8", q_val, 4'd2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule